// File: doc/BRIEF.md
# Grouped Interrupt Expansion Controller

This block gathers ninety-six peripheral request inputs into a small set of CPU interrupt lines. The sources are arranged as twelve groups of eight. Each source has a sticky pending bit and an enable input. Each group drives one CPU line. A group may raise its line only while its reopen latch is set. The latch closes as soon as the group raises its line, and it reopens only when software writes the group's bit in an acknowledge write. Two further CPU lines, 13 and 14, take direct requests that bypass the grouping.

On the CPU side, a 14-bit line flag register is combined with a 14-bit line enable and a global mask to form a single interrupt request. When the CPU answers with a vector-fetch strobe, the controller selects the winning line and the winning source within that group. It reports both in a response that is valid for one cycle, and it clears the line flag and the source's pending bit in the same clock edge. A software-side handler would serve the source and then acknowledge the group so that the group can raise its line again.

Top module: `grouped_irq_ctrl`

## Requirements
- R1: Source s (1..8) of group g (1..12) sits at bit (g-1)*8+(s-1) of `src_req`, `src_en` and `src_pend`. A high `src_req` bit sets the matching `src_pend` bit at the next clock edge. The bit stays set until a vector fetch serves that source, and a request in the same edge as the clear wins.
- R2: Group g drives line g, which is `line_flag` bit g-1. The line flag sets one edge after the group has a pending, enabled source while `exp_en` is 1 and the group's reopen latch is set.
- R3: A pending source whose `src_en` bit is 0 does not raise its line. While `exp_en` is 0, no group raises its line, although pending bits still record requests.
- R4: Raising a line closes the group's reopen latch. No further raise happens until an edge with `ack_wr` high and `ack_bits` bit g-1 at 1. Acknowledge bits of other groups leave the latch closed.
- R5: `irq_out` is high exactly when `cpu_mask` is 0 and some line has both its flag and its `cpu_ie` bit set.
- R6: When `vec_fetch` is high at an edge while `irq_out` is high, `vec_valid` is 1 for the following cycle. `vec_grp` then carries the lowest-numbered line (1..14) with flag and enable set. `vec_idx` carries s-1 for the lowest-indexed source of that group whose pending and enable bits are both set.
- R7: The serving edge clears the selected line flag and the reported source's pending bit.
- R8: A `vec_fetch` while `irq_out` is low yields no `vec_valid` and changes no flag.
- R9: `aux_req` bit a sets flag of line 13+a (bit 12+a). A fetch serving it returns that line number with `vec_idx` 0 and clears the flag, and a new request in the same edge wins.
- R10: Reset, synchronous and active high, clears every pending bit, line flag and `vec_valid`, and sets every reopen latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exp_en | input | 1 | Global expander enable |
| src_req | input | 96 | Per-source request pulses |
| src_en | input | 96 | Per-source enables |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_bits | input | 12 | Groups to reopen, bit g-1 for group g |
| aux_req | input | 2 | Direct requests for lines 13 and 14 |
| cpu_ie | input | 14 | CPU line enables |
| cpu_mask | input | 1 | Global mask, 1 blocks all lines |
| vec_fetch | input | 1 | CPU vector-fetch strobe |
| src_pend | output | 96 | Source pending bits |
| line_flag | output | 14 | CPU line flags |
| irq_out | output | 1 | Interrupt request to the CPU |
| vec_valid | output | 1 | Fetch response valid, one cycle |
| vec_grp | output | 4 | Served line number, 1..14 |
| vec_idx | output | 3 | Served source index minus one |

## Verification
The assertions assume that `vec_fetch` and `ack_wr` are single-cycle strobes that may occur in any cycle, including cycles in which the mask is set or nothing is pending. They also assume that requests can land on a source in the very edge that clears it. The random stimulus therefore fires fetches and acknowledges freely, toggles enables and the mask, and drops sparse requests on arbitrary bits, so that these overlaps occur instead of being avoided. The directed cases pin down the closed-latch and priority orderings with concrete line and index values.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
    localparam int NGRP  = 12;
    localparam int NSRC  = 8;
    localparam int NLINE = 14;
    localparam int NAUX  = NLINE - NGRP;
    localparam int NBIT  = NGRP * NSRC;
    localparam int GW    = $clog2(NLINE + 1);
    localparam int IW    = $clog2(NSRC);

    typedef struct packed {
        logic          valid;
        logic [GW-1:0] grp;
        logic [IW-1:0] idx;
    } vec_resp_t;

    function automatic logic [IW-1:0] first_src(input logic [NSRC-1:0] v);
        logic [IW-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--)
            if (v[i]) r = IW'(i);
        return r;
    endfunction

    function automatic logic [GW-1:0] first_line(input logic [NLINE-1:0] v);
        logic [GW-1:0] r;
        r = '0;
        for (int i = NLINE - 1; i >= 0; i--)
            if (v[i]) r = GW'(i + 1);
        return r;
    endfunction
endpackage

// File: rtl/irqx_group.sv
module irqx_group
    import irqx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            exp_en,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] en,
    input  logic            ack,
    input  logic            fetch_hit,
    output logic            line_q,
    output logic [NSRC-1:0] src_q,
    output logic [IW-1:0]   hit_idx
);
    logic            open_q;
    logic [NSRC-1:0] avail;
    logic            hit_any;
    logic            raise;
    logic [NSRC-1:0] clr_vec;

    assign avail   = src_q & en;
    assign hit_any = |avail;
    assign hit_idx = first_src(avail);
    assign raise   = exp_en & hit_any & open_q;

    always_comb begin
        clr_vec = '0;
        if (fetch_hit && hit_any) clr_vec[hit_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            line_q <= 1'b0;
            open_q <= 1'b1;
        end else begin
            src_q  <= (src_q & ~clr_vec) | req;
            line_q <= raise | (line_q & ~fetch_hit);
            if (raise)    open_q <= 1'b0;
            else if (ack) open_q <= 1'b1;
        end
    end

    p_close_on_raise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(line_q) |-> !open_q);
    p_stay_closed_r4: assert property (@(posedge clk) disable iff (rst)
        (!open_q && !ack) |=> !$rose(line_q));
    p_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        !fetch_hit |=> ((src_q & $past(src_q)) == $past(src_q)));
    p_fetch_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (fetch_hit && !open_q) |=> !line_q);
endmodule

// File: rtl/irqx_line_arb.sv
module irqx_line_arb
    import irqx_pkg::*;
(
    input  logic [NLINE-1:0] line_q,
    input  logic [NLINE-1:0] ie,
    input  logic             mask,
    input  logic             fetch,
    output logic             irq,
    output logic             serve,
    output logic [NLINE-1:0] sel_oh,
    output logic [GW-1:0]    sel_num
);
    logic [NLINE-1:0] cand;

    assign cand    = line_q & ie;
    assign irq     = ~mask & (|cand);
    assign serve   = fetch & irq;
    assign sel_oh  = cand & (~cand + NLINE'(1));
    assign sel_num = first_line(cand);
endmodule

// File: rtl/grouped_irq_ctrl.sv
module grouped_irq_ctrl
    import irqx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             exp_en,
    input  logic [NBIT-1:0]  src_req,
    input  logic [NBIT-1:0]  src_en,
    input  logic             ack_wr,
    input  logic [NGRP-1:0]  ack_bits,
    input  logic [NAUX-1:0]  aux_req,
    input  logic [NLINE-1:0] cpu_ie,
    input  logic             cpu_mask,
    input  logic             vec_fetch,
    output logic [NBIT-1:0]  src_pend,
    output logic [NLINE-1:0] line_flag,
    output logic             irq_out,
    output logic             vec_valid,
    output logic [GW-1:0]    vec_grp,
    output logic [IW-1:0]    vec_idx
);
    logic [NLINE-1:0] line_vec;
    logic [NLINE-1:0] sel_oh;
    logic [GW-1:0]    sel_num;
    logic             serve;
    logic [IW-1:0]    grp_idx [NGRP];
    logic [IW-1:0]    pick_idx;
    vec_resp_t        resp_q;

    irqx_line_arb u_arb (
        .line_q (line_vec),
        .ie     (cpu_ie),
        .mask   (cpu_mask),
        .fetch  (vec_fetch),
        .irq    (irq_out),
        .serve  (serve),
        .sel_oh (sel_oh),
        .sel_num(sel_num)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        irqx_group u_grp (
            .clk      (clk),
            .rst      (rst),
            .exp_en   (exp_en),
            .req      (src_req[g*NSRC +: NSRC]),
            .en       (src_en[g*NSRC +: NSRC]),
            .ack      (ack_wr & ack_bits[g]),
            .fetch_hit(serve & sel_oh[g]),
            .line_q   (line_vec[g]),
            .src_q    (src_pend[g*NSRC +: NSRC]),
            .hit_idx  (grp_idx[g])
        );
    end

    for (genvar a = 0; a < NAUX; a++) begin : g_aux
        logic aux_q;
        always_ff @(posedge clk) begin
            if (rst) aux_q <= 1'b0;
            else     aux_q <= aux_req[a] | (aux_q & ~(serve & sel_oh[NGRP+a]));
        end
        assign line_vec[NGRP+a] = aux_q;
    end

    always_comb begin
        pick_idx = '0;
        for (int g = 0; g < NGRP; g++)
            if (sel_oh[g]) pick_idx = grp_idx[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.valid <= serve;
            if (serve) begin
                resp_q.grp <= sel_num;
                resp_q.idx <= pick_idx;
            end
        end
    end

    assign line_flag = line_vec;
    assign vec_valid = resp_q.valid;
    assign vec_grp   = resp_q.grp;
    assign vec_idx   = resp_q.idx;

    p_valid_after_fetch_r6: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(vec_fetch));
    p_unmasked_r5: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> !$past(cpu_mask));
    p_grp_range_r6: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_grp >= GW'(1) && vec_grp <= GW'(NLINE)));
endmodule

// File: tb/sim_grouped_irq_ctrl.sv
module sim_grouped_irq_ctrl;
    import irqx_pkg::*;

    logic clk = 0, rst = 1;
    logic exp_en = 1, ack_wr = 0, cpu_mask = 0, vec_fetch = 0;
    logic [NBIT-1:0]  src_req = '0, src_en = '1;
    logic [NGRP-1:0]  ack_bits = '0;
    logic [NAUX-1:0]  aux_req = '0;
    logic [NLINE-1:0] cpu_ie = '1;
    logic [NBIT-1:0]  src_pend;
    logic [NLINE-1:0] line_flag;
    logic irq_out, vec_valid;
    logic [GW-1:0] vec_grp;
    logic [IW-1:0] vec_idx;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    grouped_irq_ctrl u0 (.*);

    // bench model
    logic [NBIT-1:0]  m_src;
    logic [NLINE-1:0] m_line;
    logic [NGRP-1:0]  m_open;
    logic m_vv; logic [GW-1:0] m_vg; logic [IW-1:0] m_vi;

    function automatic int low_bit(input logic [NLINE-1:0] v);
        for (int i = 0; i < NLINE; i++) if (v[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        logic [NBIT-1:0] clr; logic [NLINE-1:0] lclr, cand;
        logic [NGRP-1:0] raise; logic [NSRC-1:0] av; int sel; int fi;
        if (rst) begin
            m_src <= '0; m_line <= '0; m_open <= '1; m_vv <= 0; m_vg <= '0; m_vi <= '0;
        end else begin
            clr = '0; lclr = '0; fi = 0;
            cand = m_line & cpu_ie;
            for (int g = 0; g < NGRP; g++)
                raise[g] = exp_en && m_open[g] && |(m_src[g*NSRC +: NSRC] & src_en[g*NSRC +: NSRC]);
            if (vec_fetch && !cpu_mask && cand != 0) begin
                sel = low_bit(cand); lclr[sel] = 1;
                if (sel < NGRP) begin
                    av = m_src[sel*NSRC +: NSRC] & src_en[sel*NSRC +: NSRC];
                    for (int i = NSRC - 1; i >= 0; i--) if (av[i]) fi = i;
                    if (av != 0) clr[sel*NSRC + fi] = 1;
                end
                m_vv <= 1; m_vg <= GW'(sel + 1); m_vi <= IW'(fi);
            end else m_vv <= 0;
            m_src <= (m_src & ~clr) | src_req;
            for (int g = 0; g < NGRP; g++) begin
                m_line[g] <= raise[g] | (m_line[g] & ~lclr[g]);
                if (raise[g]) m_open[g] <= 0;
                else if (ack_wr && ack_bits[g]) m_open[g] <= 1;
            end
            for (int a = 0; a < NAUX; a++)
                m_line[NGRP+a] <= aux_req[a] | (m_line[NGRP+a] & ~lclr[NGRP+a]);
        end
    end

    task automatic chk(input string r, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // continuous comparison against the model
    always begin
        @(negedge clk); #5;
        if (!rst) begin
            chk("R1 src_pend", src_pend, m_src);
            chk("R2 line_flag", line_flag, m_line);
            chk("R5 irq_out", irq_out, !cpu_mask && (m_line & cpu_ie) != 0);
            chk("R6 vec_valid", vec_valid, m_vv);
            if (m_vv) chk("R6 vec_grp/idx", {vec_grp, vec_idx}, {m_vg, m_vi});
        end
    end

    task automatic step(); @(posedge clk); @(negedge clk); endtask
    task automatic fetch1(); vec_fetch = 1; step(); vec_fetch = 0; #2; endtask
    task automatic ack(input logic [NGRP-1:0] b); ack_wr = 1; ack_bits = b; step(); ack_wr = 0; ack_bits = '0; endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) step();
        #2;
        chk("R10 pend", src_pend, '0); chk("R10 lines", line_flag, '0); chk("R10 valid", vec_valid, 0);
        rst = 0; step();
        // R1/R2: group 12 source 1 -> line 12
        src_req[88] = 1; step(); src_req = '0; #2;
        chk("R1 set", src_pend[88], 1); chk("R2 not yet", line_flag[11], 0);
        step(); #2;
        chk("R2 line12", line_flag[11], 1); chk("R5 irq", irq_out, 1);
        cpu_mask = 1; #2; chk("R5 masked", irq_out, 0);
        fetch1(); chk("R8 no valid", vec_valid, 0); chk("R8 kept", line_flag[11], 1);
        cpu_mask = 0; fetch1();
        chk("R6 valid", vec_valid, 1); chk("R6 grp", vec_grp, 12); chk("R6 idx", vec_idx, 0);
        chk("R7 line clr", line_flag[11], 0); chk("R7 src clr", src_pend[88], 0);
        step(); #2; chk("R6 one cycle", vec_valid, 0);
        // R4: closed until acknowledged
        src_req[88] = 1; step(); src_req = '0; step(); step(); #2;
        chk("R4 closed", line_flag[11], 0); chk("R1 held", src_pend[88], 1);
        ack(12'h7FF); step(); #2; chk("R4 other ack", line_flag[11], 0);
        ack(12'h800); step(); #2; chk("R4 reopened", line_flag[11], 1);
        fetch1(); chk("R6 grp12", vec_grp, 12); ack(12'h800);
        // R3: disabled source, then global disable
        src_en[16] = 0; src_req[16] = 1; step(); src_req = '0; step(); step(); #2;
        chk("R3 src disabled", line_flag[2], 0); chk("R3 pend", src_pend[16], 1);
        src_en = '1; exp_en = 0; step(); step(); #2; chk("R3 exp off", line_flag[2], 0);
        exp_en = 1; step(); step(); #2; chk("R3 exp on", line_flag[2], 1);
        // R6 priority: g3 s1,s6 and g5 s3
        src_req[21] = 1; src_req[34] = 1; step(); src_req = '0; step(); step(); #2;
        chk("R2 line5", line_flag[4], 1);
        cpu_ie = ~14'h0004; fetch1(); chk("R6 ie skip", {vec_grp, vec_idx}, {4'd5, 3'd2});
        cpu_ie = '1; fetch1(); chk("R6 low line", {vec_grp, vec_idx}, {4'd3, 3'd0});
        ack(12'h004); step(); #2; fetch1(); chk("R6 low src", {vec_grp, vec_idx}, {4'd3, 3'd5});
        // R9 aux line 14
        aux_req = 2'b10; step(); aux_req = '0; #2; chk("R9 set", line_flag[13], 1);
        fetch1(); chk("R9 grp", {vec_grp, vec_idx}, {4'd14, 3'd0}); chk("R9 clr", line_flag[13], 0);
        ack('1); step();
        // random phase
        for (int c = 0; c < 3000; c++) begin
            src_req = '0;
            for (int k = 0; k < 3; k++) if ($urandom % 4 == 0) src_req[$urandom % NBIT] = 1;
            if ($urandom % 32 == 0) src_en[$urandom % NBIT] ^= 1;
            exp_en = ($urandom % 16) != 0;
            ack_wr = ($urandom % 4) == 0; ack_bits = NGRP'($urandom);
            aux_req = (($urandom % 16) == 0) ? NAUX'($urandom) : '0;
            cpu_ie = (($urandom % 8) == 0) ? NLINE'($urandom) : '1;
            cpu_mask = ($urandom % 8) == 0;
            vec_fetch = $urandom % 2;
            step();
        end
        src_req = '0; ack_wr = 0; vec_fetch = 0; step(); step();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule